// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a clocked host to an asynchronous static RAM of 256K words by 32 bits. Each byte lane of the memory has its own active-low select. The host posts one request at a time with a request/ready handshake. A request carries a word address, write data, a byte mask and a read/write flag. The controller then drives the memory's address, lane selects, write strobe, output enable and shared data bus through a fixed sequence of clock phases. The lengths of these phases are parameters, so an integrator can meet the memory's nanosecond minimums at the chosen clock rate.

A write passes through three phases:
- an address-setup phase, with the chosen lanes selected;
- a strobe phase, with the write strobe low;
- a hold phase, in which the controller keeps driving the bus after the strobe has risen.

A read selects all four lanes with the output enable low for a set number of cycles. It captures the whole word on the last of those cycles and then raises a one-cycle valid pulse. The controller also registers the two density-identify pins of the memory for the host to inspect.

Top module: `sram_lane_ctrl`

## Requirements
- R1: `rdy` is high only while the controller is idle. A request is accepted on a rising edge where `req` and `rdy` are both high. After accepting any request other than a zero-mask write, `rdy` is low in the following cycle.
- R2: A write with a non-zero mask keeps its selects low for SETUP_CYC cycles before `mem_we_n` falls. `mem_we_n` then stays low for exactly PULSE_CYC cycles, and the selects stay low for HOLD_CYC cycles after it rises. `rdy` returns after SETUP_CYC+PULSE_CYC+HOLD_CYC busy cycles.
- R3: During a write, `mem_cs_n[b]` is low exactly when `be[b]` was set. Bit b gates data bits 8b+7:8b. Lanes that are not selected keep their old memory contents.
- R4: The controller drives `mem_dq` only during the strobe and hold phases, and with the write data then. `mem_oe_n` stays high for the whole of a write.
- R5: A read drives all four selects low, `mem_we_n` high and `mem_oe_n` low for ACCESS_CYC cycles, whatever the value of `be`. The word captured on the last of those cycles appears on `rdata`. `rvalid` is high for exactly one cycle, starting ACCESS_CYC rising edges after the accepting edge.
- R6: A write with `be` equal to zero asserts no select and no strobe, and `rdy` stays high.
- R7: During reset and while idle, all selects, `mem_we_n` and `mem_oe_n` are high, and the controller does not drive the bus.
- R8: `mem_addr` holds the accepted address and stays stable from the accepting edge until `rdy` returns.
- R9: `density_id` shows the value of `id_pins` registered on the previous rising edge. It reads 0 with both pins grounded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request |
| rdy | output | 1 | Controller idle, request can be accepted |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte mask for writes, bit b for bits 8b+7:8b |
| rdata | output | 32 | Captured read word |
| rvalid | output | 1 | One-cycle read data valid |
| id_pins | input | 2 | Memory density-identify pins |
| density_id | output | 2 | Registered density-identify value |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 4 | Active-low lane selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | inout | 32 | Shared memory data bus |

## Verification
The bench counts falling clock edges from the edge that accepted each request, and compares each result against its due cycle:

| Result | Due cycle after the accepting edge |
|---|---|
| Selects | first falling edge |
| Write strobe | falls at falling edge SETUP_CYC |
| `rdy` | returns after SETUP_CYC+PULSE_CYC+HOLD_CYC edges |
| `rvalid` | rises at edge ACCESS_CYC |

Every sample is taken at the falling edge, half a period after the register that produces it, so each value is read in the cycle it belongs to. A zero-mask write is checked at the falling edge straight after its accepting edge, where `rdy` must still be high. Read data is compared against a bench reference that merges each masked write into its own copy of the words.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW = 18,
  parameter int DW = 32,
  parameter int IDW = 2,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          rdy,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW/8-1:0] be,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  input  logic [IDW-1:0] id_pins,
  output logic [IDW-1:0] density_id,
  output logic [AW-1:0] mem_addr,
  output logic [DW/8-1:0] mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  inout  wire  [DW-1:0] mem_dq
);
  localparam int NB = DW / 8;
  localparam int M1 = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2 = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {IDLE, SETUP, STROBE, HOLD, ACCESS, CAPTURE} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic [NB-1:0] m_q;
  logic [IDW-1:0] id_q;
  logic sel, drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      a_q <= '0;
      d_q <= '0;
      m_q <= '0;
      rdata <= '0;
      id_q <= '0;
    end else begin
      id_q <= id_pins;
      case (st)
        IDLE: if (req) begin
          a_q <= addr;
          d_q <= wdata;
          m_q <= wr ? be : '1;
          if (!wr) begin
            st <= ACCESS;
            cnt <= CW'(ACCESS_CYC - 1);
          end else if (be != '0) begin
            st <= SETUP;
            cnt <= CW'(SETUP_CYC - 1);
          end
        end
        SETUP: if (cnt == '0) begin
          st <= STROBE;
          cnt <= CW'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        STROBE: if (cnt == '0) begin
          st <= HOLD;
          cnt <= CW'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        HOLD: if (cnt == '0) st <= IDLE;
              else cnt <= cnt - 1'b1;
        ACCESS: if (cnt == '0) begin
          rdata <= mem_dq;
          st <= CAPTURE;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assign sel = (st == SETUP) || (st == STROBE) || (st == HOLD) || (st == ACCESS);
  assign drv = (st == STROBE) || (st == HOLD);
  assign rdy = (st == IDLE);
  assign rvalid = (st == CAPTURE);
  assign mem_addr = a_q;
  assign mem_cs_n = sel ? ~m_q : '1;
  assign mem_we_n = (st != STROBE);
  assign mem_oe_n = (st != ACCESS);
  assign mem_dq = drv ? d_q : 'z;
  assign density_id = id_q;
endmodule

module sram_lane_ctrl_chk #(
  parameter int AW = 18,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          wr,
  input logic [NB-1:0] be,
  input logic          rdy,
  input logic          rvalid,
  input logic [AW-1:0] mem_addr,
  input logic [NB-1:0] mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          drv
);
  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && rdy && !(wr && be == '0)) |=> !rdy);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (&mem_cs_n && mem_we_n && mem_oe_n && !drv));
  // R4
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> mem_oe_n);
  // R2
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!(&mem_cs_n) && $past(mem_cs_n) == mem_cs_n));
  // R3
  lanes_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_cs_n));
  // R5
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && !$past(rdy)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW), .NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .be(be), .rdy(rdy),
  .rvalid(rvalid), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .drv(drv)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;
  localparam int SC = 1, PC = 2, HC = 1, AC = 2;
  logic clk = 0, rst_n = 0, req = 0, wr = 0, rvalid, rdy;
  logic [17:0] addr = 0, mem_addr;
  logic [31:0] wdata = 0, rdata;
  logic [3:0] be = 0, mem_cs_n;
  logic [1:0] id_pins = 2'b00, density_id;
  logic mem_we_n, mem_oe_n;
  wire [31:0] mem_dq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] mw [1024];
  logic [31:0] refm [1024];

  always #10 clk = ~clk;

  sram_lane_ctrl #(.SETUP_CYC(SC), .PULSE_CYC(PC), .HOLD_CYC(HC), .ACCESS_CYC(AC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .rdy(rdy), .wr(wr), .addr(addr),
    .wdata(wdata), .be(be), .rdata(rdata), .rvalid(rvalid), .id_pins(id_pins),
    .density_id(density_id), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq));

  for (genvar b = 0; b < 4; b++) begin : g_mdrv
    assign mem_dq[b*8+:8] = (mem_we_n && !mem_oe_n && !mem_cs_n[b]) ?
                            mw[mem_addr[9:0]][b*8+:8] : 8'hzz;
  end

  always @(posedge clk)
    if (!mem_we_n)
      for (int b = 0; b < 4; b++)
        if (!mem_cs_n[b]) mw[mem_addr[9:0]][b*8+:8] <= mem_dq[b*8+:8];

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d, input logic [3:0] m);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (m[b]) r[b*8+:8] = d[b*8+:8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_write(input logic [17:0] a, input logic [31:0] d, input logic [3:0] m);
    int busy = 0, welow = 0, first_we = -1;
    bit cs_bad = 0, oe_bad = 0, ad_bad = 0, dq_bad = 0;
    @(negedge clk); req = 1; wr = 1; addr = a; wdata = d; be = m;
    @(negedge clk); req = 0;
    if (m == 4'h0) begin
      chk(rdy && &mem_cs_n && mem_we_n, "R6 zero-mask write quiet", {mem_cs_n, mem_we_n, rdy}, {4'hf, 1'b1, 1'b1});
      return;
    end
    chk(!rdy, "R1 rdy low after accept", rdy, 0);
    while (!rdy && busy < 64) begin
      if (!mem_we_n) begin
        welow++;
        if (first_we < 0) first_we = busy;
        if (mem_dq !== d) dq_bad = 1;
      end
      if (mem_cs_n != ~m) cs_bad = 1;
      if (!mem_oe_n) oe_bad = 1;
      if (mem_addr != a) ad_bad = 1;
      busy++;
      @(negedge clk);
    end
    chk(busy == SC + PC + HC, "R2 write busy cycles", busy, SC + PC + HC);
    chk(first_we == SC, "R2 strobe start", first_we, SC);
    chk(welow == PC, "R2 strobe width", welow, PC);
    chk(!cs_bad, "R3 lane selects", cs_bad, 0);
    chk(!oe_bad && !dq_bad, "R4 oe high and data driven", {oe_bad, dq_bad}, 0);
    chk(!ad_bad, "R8 address stable", ad_bad, 0);
    refm[a[9:0]] = merge(refm[a[9:0]], d, m);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [3:0] m);
    int lat = 0;
    bit bad = 0;
    @(negedge clk); req = 1; wr = 0; addr = a; be = m; wdata = $urandom;
    @(negedge clk); req = 0;
    while (!rvalid && lat < 64) begin
      if (mem_cs_n != 4'h0 || !mem_we_n || mem_oe_n || mem_addr != a) bad = 1;
      lat++;
      @(negedge clk);
    end
    chk(lat == AC, "R5 rvalid latency", lat, AC);
    chk(!bad, "R5 read strobes all lanes", bad, 0);
    chk(rdata == refm[a[9:0]], "R3 R5 read data", rdata, refm[a[9:0]]);
    @(negedge clk);
    chk(!rvalid && rdy, "R5 rvalid one cycle", {rvalid, rdy}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) begin mw[i] = 0; refm[i] = 0; end
    repeat (3) @(negedge clk);
    chk(rdy && &mem_cs_n && mem_we_n && mem_oe_n && !rvalid, "R7 reset outputs",
        {rdy, mem_cs_n, mem_we_n, mem_oe_n, rvalid}, 8'b11111110);
    rst_n = 1;
    @(negedge clk);
    chk(density_id == 2'b00, "R9 density grounded", density_id, 0);
    chk(rdy, "R1 rdy idle", rdy, 1);
    do_write(18'h3FFFF, 32'hDEADBEEF, 4'hF);
    do_read(18'h3FFFF, 4'h0);
    do_write(18'h00005, 32'h11223344, 4'hF);
    do_write(18'h00005, 32'hAABBCCDD, 4'h1);
    do_write(18'h00005, 32'h55667788, 4'h8);
    do_read(18'h00005, 4'h2);
    do_write(18'h00005, 32'hFFFFFFFF, 4'h0);
    do_read(18'h00005, 4'h0);
    do_write(18'h00000, 32'h0F0F0F0F, 4'h6);
    do_read(18'h00000, 4'hF);
    id_pins = 2'b10;
    @(negedge clk);
    chk(density_id == 2'b10, "R9 density follows pins", density_id, 2'b10);
    id_pins = 2'b00;
    for (int i = 0; i < 300; i++) begin
      logic [17:0] ra = 18'($urandom % 1000);
      if ($urandom % 2) do_write(ra, $urandom, 4'($urandom));
      else do_read(ra, 4'($urandom));
    end
    @(negedge clk);
    chk(density_id == 2'b00, "R9 density back", density_id, 0);
    summary();
  end
endmodule